// File: doc/BRIEF.md
# Iterative AES-128 Block Decryption Core

This core turns one 128-bit AES-128 ciphertext block back into plaintext. Software or a neighbouring block writes the ciphertext as four 32-bit words, most significant word first, into a gathering register. A start pulse then launches the computation. In the launch cycle the gathered block is XORed with round key 10. Ten inverse rounds follow, one per clock. Each round reverses the row shifts, passes every byte through the inverse substitution box and adds its round key. The first nine rounds also unmix the columns; the tenth does not.

The expanded key schedule lives outside the core in a table of eleven 128-bit keys. The core presents a round index and expects that key on its key input within the same cycle. When the last round completes, the plaintext is captured in an output buffer and an end-of-conversion flag rises. The buffer is then read word by word through a word selector.

Top module: `aes_inv_core`

## Requirements
- R1: After reset `busy` and `eoc` are 0, `key_idx` is 10 and every word read through `out_sel` is zero.
- R2: Each cycle with `in_we` high shifts `in_word` into the gathering register from the low end. After four writes, the first word written forms bits 127:96 of the ciphertext (FIPS-197 byte order, byte 0 in bits 127:120).
- R3: While idle, `key_idx` shows 10. In the cycles after an accepted start it shows 9, 8, … 0, one step per clock, and then returns to 10.
- R4: A start that is accepted on a clock edge raises `busy` on that edge. Exactly 10 clock edges later `busy` falls and `eoc` rises. `eoc` stays 0 on the nine edges between.
- R5: The result equals the AES-128 inverse cipher of the gathered block under the key table (initial XOR with key 10, round r using key 10−r). Nine full rounds are followed by a final round without inverse mix columns.
- R6: Inverse shift rows rotates row i of the state (bytes i, i+4, i+8, i+12) right by i byte positions. The inverse byte substitution is the exact inverse of the AES forward S-box for all 256 byte values.
- R7: A start pulse while `busy` is 1 is ignored. Completion time and result of the running block are unchanged.
- R8: `out_word` shows word `out_sel` of the result, where 0 selects bits 127:96 and 3 selects bits 31:0. The buffer keeps the previous result until the next block completes, including while a new block is running.
- R9: An accepted start clears `eoc` on the same edge. Without an accepted start, `eoc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we | input | 1 | Shift `in_word` into the gathering register |
| in_word | input | 32 | Ciphertext word, most significant word first |
| start | input | 1 | Launch decryption of the gathered block when idle |
| key_idx | output | 4 | Round key number requested from the key table |
| key_word | input | 128 | Round key for `key_idx`, valid in the same cycle |
| busy | output | 1 | Rounds in progress |
| eoc | output | 1 | Result available in the output buffer |
| out_sel | input | 2 | Output word selector, 0 = most significant |
| out_word | output | 32 | Selected result word |

## Verification
On every cycle, the assertions check that the round counter stays in range while busy and that `key_idx` counts down one step per round. They also check that `eoc` rises only after round 10, that a start during a run neither disturbs the counter nor clears `eoc`, and that the output buffer changes only on completion. Whether the arithmetic is right, meaning the inverse S-box, the row rotation direction, the column unmixing and the key ordering, can only be shown by the bench's scenarios. These cover the standard test vectors, plaintexts encrypted by an independent forward model, and ciphertexts that together cover every byte value and are re-encrypted to check the round trip.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;
  localparam int BLK_W      = 128;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = BLK_W / WORD_W;
  localparam int NUM_BYTES  = BLK_W / 8;
  localparam int NUM_ROUNDS = 10;
  localparam int KEY_IDX_W  = $clog2(NUM_ROUNDS + 1);
  localparam int SEL_W      = $clog2(NUM_WORDS);

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_xtime(x);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring: exponents 2+4+...+128
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 7; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] x);
    logic [7:0] t;
    t = {x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05;
    return gf_inv(t);
  endfunction

  // byte k = 4*column + row sits at bits 127-8k
  function automatic logic [BLK_W-1:0] inv_shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*((c+4-r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] inv_mix_columns(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    logic [7:0] a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = s[BLK_W-1-32*c -: 8];
      a1 = s[BLK_W-9-32*c -: 8];
      a2 = s[BLK_W-17-32*c -: 8];
      a3 = s[BLK_W-25-32*c -: 8];
      o[BLK_W-1-32*c -: 8]  = gf_mul(a0,8'h0e)^gf_mul(a1,8'h0b)^gf_mul(a2,8'h0d)^gf_mul(a3,8'h09);
      o[BLK_W-9-32*c -: 8]  = gf_mul(a0,8'h09)^gf_mul(a1,8'h0e)^gf_mul(a2,8'h0b)^gf_mul(a3,8'h0d);
      o[BLK_W-17-32*c -: 8] = gf_mul(a0,8'h0d)^gf_mul(a1,8'h09)^gf_mul(a2,8'h0e)^gf_mul(a3,8'h0b);
      o[BLK_W-25-32*c -: 8] = gf_mul(a0,8'h0b)^gf_mul(a1,8'h0d)^gf_mul(a2,8'h09)^gf_mul(a3,8'h0e);
    end
    return o;
  endfunction
endpackage

// File: rtl/aes_in_gather.sv
module aes_in_gather
  import aes_inv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  output logic [BLK_W-1:0]  blk
);
  logic [BLK_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else if (we) shreg_q <= {shreg_q[BLK_W-WORD_W-1:0], word};
  end

  assign blk = shreg_q;
endmodule

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
  import aes_inv_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  assign dout = inv_sbox(din);
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
  import aes_inv_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  logic [BLK_W-1:0] shifted;
  logic [BLK_W-1:0] subbed;
  logic [BLK_W-1:0] keyed;

  assign shifted = inv_shift_rows(state_i);

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_sbox
    aes_inv_sbox u_sbox (
      .din  (shifted[8*k +: 8]),
      .dout (subbed[8*k +: 8])
    );
  end

  assign keyed   = subbed ^ rkey_i;
  assign state_o = last_i ? keyed : inv_mix_columns(keyed);
endmodule

// File: rtl/aes_out_buf.sv
module aes_out_buf
  import aes_inv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  din,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  logic [BLK_W-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (load) buf_q <= din;
  end

  assign word = buf_q[BLK_W-1-WORD_W*int'(sel) -: WORD_W];

  // R8: result buffer changes only on completion
  a_r8_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(buf_q));
endmodule

// File: rtl/aes_inv_core.sv
module aes_inv_core
  import aes_inv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_we,
  input  logic [WORD_W-1:0]    in_word,
  input  logic                 start,
  output logic [KEY_IDX_W-1:0] key_idx,
  input  logic [BLK_W-1:0]     key_word,
  output logic                 busy,
  output logic                 eoc,
  input  logic [SEL_W-1:0]     out_sel,
  output logic [WORD_W-1:0]    out_word
);
  localparam logic [KEY_IDX_W-1:0] LAST_RND = KEY_IDX_W'(NUM_ROUNDS);

  logic [BLK_W-1:0]     cipher_blk;
  logic [BLK_W-1:0]     state_q;
  logic [BLK_W-1:0]     round_out;
  logic [KEY_IDX_W-1:0] rnd_q;
  logic                 busy_q;
  logic                 eoc_q;

  // named events for assertions
  logic start_acc;
  logic last_round;
  logic done_pulse;

  assign start_acc  = start && !busy_q;
  assign last_round = (rnd_q == LAST_RND);
  assign done_pulse = busy_q && last_round;

  aes_in_gather u_gather (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (in_we),
    .word  (in_word),
    .blk   (cipher_blk)
  );

  aes_inv_round u_round (
    .state_i (state_q),
    .rkey_i  (key_word),
    .last_i  (last_round),
    .state_o (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      rnd_q   <= '0;
      busy_q  <= 1'b0;
      eoc_q   <= 1'b0;
    end else if (start_acc) begin
      state_q <= cipher_blk ^ key_word;
      rnd_q   <= KEY_IDX_W'(1);
      busy_q  <= 1'b1;
      eoc_q   <= 1'b0;
    end else if (busy_q) begin
      state_q <= round_out;
      if (last_round) begin
        busy_q <= 1'b0;
        eoc_q  <= 1'b1;
        rnd_q  <= '0;
      end else begin
        rnd_q <= rnd_q + KEY_IDX_W'(1);
      end
    end
  end

  assign key_idx = busy_q ? (LAST_RND - rnd_q) : LAST_RND;
  assign busy    = busy_q;
  assign eoc     = eoc_q;

  aes_out_buf u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (done_pulse),
    .din   (round_out),
    .sel   (out_sel),
    .word  (out_word)
  );

  // R4: counter in range while busy
  a_r4_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rnd_q >= KEY_IDX_W'(1)) && (rnd_q <= LAST_RND));

  // R4: completion flag rises only after the tenth round
  a_r4_eoc_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_q) |-> $past(busy_q) && ($past(rnd_q) == LAST_RND));

  // R3: key index walks down one step per round
  a_r3_key_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_round) |=> (key_idx == $past(key_idx) - KEY_IDX_W'(1)));

  // R7: start during a run does not disturb the counter
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last_round) |=> busy_q && (rnd_q == $past(rnd_q) + KEY_IDX_W'(1)));

  // R9: accepted start clears the flag
  a_r9_eoc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !eoc_q);

  // R9: flag holds while idle and no start
  a_r9_eoc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(eoc_q));
endmodule

// File: tb/aes_inv_core_bench.sv
module aes_inv_core_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_we = 1'b0;
  logic [31:0]  in_word = '0;
  logic         start = 1'b0;
  logic [3:0]   key_idx;
  logic [127:0] key_word;
  logic         busy;
  logic         eoc;
  logic [1:0]   out_sel = '0;
  logic [31:0]  out_word;

  int checks = 0;
  int fails  = 0;

  logic [7:0]   fsb [256];
  logic [127:0] rk [11];

  always #10 clk = ~clk;

  assign key_word = (key_idx <= 4'd10) ? rk[key_idx] : '0;

  aes_inv_core u_aes_inv_core (
    .clk(clk), .rst_n(rst_n), .in_we(in_we), .in_word(in_word), .start(start),
    .key_idx(key_idx), .key_word(key_word), .busy(busy), .eoc(eoc),
    .out_sel(out_sel), .out_word(out_word)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // product via carry-less multiply then reduction by 0x11b
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] s, input int k);
    return s[127-8*k -: 8];
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {fsb[w[31:24]], fsb[w[23:16]], fsb[w[15:8]], fsb[w[7:0]]};
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] encrypt(input logic [127:0] pt);
    logic [127:0] s, t;
    logic [7:0] a0, a1, a2, a3;
    s = pt ^ rk[0];
    for (int r = 1; r <= 10; r++) begin
      for (int k = 0; k < 16; k++) t[127-8*k -: 8] = fsb[gb(s, k)];
      for (int c = 0; c < 4; c++)
        for (int row = 0; row < 4; row++)
          s[127-8*(4*c+row) -: 8] = gb(t, 4*((c+row)%4)+row);
      if (r < 10) begin
        t = s;
        for (int c = 0; c < 4; c++) begin
          a0 = gb(t,4*c); a1 = gb(t,4*c+1); a2 = gb(t,4*c+2); a3 = gb(t,4*c+3);
          s[127-32*c -: 8]  = bmul(a0,2)^bmul(a1,3)^a2^a3;
          s[119-32*c -: 8]  = a0^bmul(a1,2)^bmul(a2,3)^a3;
          s[111-32*c -: 8]  = a0^a1^bmul(a2,2)^bmul(a3,3);
          s[103-32*c -: 8]  = bmul(a0,3)^a1^a2^bmul(a3,2);
        end
      end
      s = s ^ rk[r];
    end
    return s;
  endfunction

  task automatic load_block(input logic [127:0] ct);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_we   = 1'b1;
      in_word = ct[127-32*i -: 32];
    end
    @(negedge clk);
    in_we = 1'b0;
  endtask

  task automatic read_out(output logic [127:0] res);
    for (int i = 0; i < 4; i++) begin
      out_sel = 2'(i);
      #1;
      res[127-32*i -: 32] = out_word;
    end
  endtask

  // launch at a negedge; returns at the negedge after completion
  task automatic run_block(input logic [127:0] ct, output logic [127:0] res);
    load_block(ct);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 10; i++) @(negedge clk);
    read_out(res);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] res, prev, pt, ct, exp;
    logic [7:0] inv;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      fsb[x] = inv ^ rotl8(inv,1) ^ rotl8(inv,2) ^ rotl8(inv,3) ^ rotl8(inv,4) ^ 8'h63;
    end
    expand(128'h000102030405060708090a0b0c0d0e0f);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && eoc == 1'b0, "R1 busy/eoc", {busy, eoc}, 0);
    check(key_idx == 4'd10, "R1 key_idx", 128'(key_idx), 10);
    read_out(res);
    check(res == '0, "R1 out", res, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R9 timing with vector C.1; R7 start while busy
    load_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(key_idx == 4'd10, "R3 idle key_idx", 128'(key_idx), 10);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && eoc == 1'b0, "R4 R9 busy after start", {busy, eoc}, 2);
    check(key_idx == 4'd9, "R3 first key", 128'(key_idx), 9);
    for (int i = 1; i <= 10; i++) begin
      if (i == 2) start = 1'b1;
      if (i == 3) start = 1'b0;
      @(negedge clk);
      check(eoc == (i == 10), $sformatf("R4 eoc edge %0d", i), 128'(eoc), 128'(i == 10));
      check(busy == (i != 10), $sformatf("R7 busy edge %0d", i), 128'(busy), 128'(i != 10));
      check(key_idx == ((i == 10) ? 4'd10 : 4'(9 - i)), $sformatf("R3 key edge %0d", i),
            128'(key_idx), 128'((i == 10) ? 10 : 9 - i));
    end
    read_out(res);
    check(res == 128'h00112233445566778899aabbccddeeff, "R2 R5 R7 vector C1", res,
          128'h00112233445566778899aabbccddeeff);
    out_sel = 2'd0; #1;
    check(out_word == 32'h00112233, "R8 word0", 128'(out_word), 128'h00112233);
    out_sel = 2'd3; #1;
    check(out_word == 32'hccddeeff, "R8 word3", 128'(out_word), 128'hccddeeff);
    repeat (3) @(negedge clk);
    check(eoc == 1'b1, "R9 eoc holds idle", 128'(eoc), 1);

    // R8 old result held during a new run
    prev = res;
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    load_block(128'h3925841d02dc09fbdc118597196a0b32);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    read_out(res);
    check(res == prev, "R8 hold during run", res, prev);
    repeat (6) @(negedge clk);
    read_out(res);
    check(res == 128'h3243f6a8885a308d313198a2e0370734, "R5 vector B", res,
          128'h3243f6a8885a308d313198a2e0370734);

    // R5 plaintexts encrypted by the bench model, three keys
    for (int kk = 0; kk < 3; kk++) begin
      expand({32'h1f2e3d4c ^ 32'(kk * 32'h9e3779b9), 32'hdeadbeef, 32'(kk), 32'h0badf00d});
      for (int b = 0; b < 8; b++) begin
        pt = {4{32'(b * 32'h01010101) ^ 32'(kk * 32'h7f4a7c15)}} ^ {96'h0, 32'(b)};
        ct = encrypt(pt);
        run_block(ct, res);
        check(res == pt, $sformatf("R5 encrypted key%0d blk%0d", kk, b), res, pt);
      end
    end

    // R6 sweep: ciphertexts covering every byte value, round trip
    expand(128'h000102030405060708090a0b0c0d0e0f);
    for (int g = 0; g < 16; g++) begin
      for (int k = 0; k < 16; k++) ct[127-8*k -: 8] = 8'(16 * g + k);
      run_block(ct, res);
      exp = encrypt(res);
      check(exp == ct, $sformatf("R6 round trip group %0d", g), exp, ct);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule